// File: doc/BRIEF.md
# Transmit Descriptor and Completion Ring Engine

This block is the transmit queue manager of a network MAC's bus-master DMA. Host software fills two-word transmit descriptors in a circular ring in memory, then writes a count to an enqueue port to announce how many new descriptors are ready. The engine walks the ring in order. For each descriptor it reads both words and hands the buffer address, length and end-of-frame marker to the transmit datapath as one frame request. When the datapath reports the outcome, the engine writes a one-word completion record into a second, independent circular ring and raises a transmit interrupt.

Each ring is defined by a base address and a byte length. The engine keeps a current address per ring and advances it by the entry size, wrapping to the base when it reaches base plus length. While transmit DMA is disabled and the engine is idle, both current addresses are reloaded from their bases. A descriptor flagged as aborted is never sent to the datapath, but it still gets a completion record. The completion record echoes the descriptor's buffer index together with the collision count and error flags, so software can match records to descriptors.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset, mem_req, frm_valid and tx_irq are low. While dma_en is low, desc_cur equals desc_base and stat_cur equals stat_base within one cycle.
- R2: Descriptor word 0 is the buffer address, read from desc_cur. Word 1 is read from desc_cur+4 and holds end-of-frame in bit 31, the buffer index in bits 30:16, an abort flag in bit 15 and the length in bits 11:0. A frame request carries word 0 on frm_addr, bits 11:0 on frm_len and bit 31 on frm_eof, and it holds these steady until frm_ready.
- R3: A completion record is one 32-bit word written at stat_cur. Bit 31 is always 1, bit 30 is the error-free flag (done_ok), bits 20:16 are done_coll_cnt and bits 14:0 echo the descriptor's buffer index. Bits 27, 23:21 and 15 are zero.
- R4: In the record, bit 28 is loss of carrier, bit 26 is out-of-window collision, bit 25 is underrun and bit 24 is excessive collisions, each copied from the datapath result.
- R5: A descriptor with the abort flag set produces no frame request. Its record has bit 29 set, bit 30 clear and all flag and count fields zero. A sent frame has bit 29 clear.
- R6: Each enq_valid cycle adds enq_cnt descriptors to the pending work. Descriptors are processed in ring order, and each one consumes exactly one record slot.
- R7: desc_cur advances by 8 and stat_cur by 4 after each record write. Each wraps to its own base when the next address would reach base plus byte length.
- R8: With no pending descriptors, or with dma_en low while idle, the engine issues no memory access.
- R9: A record write sets the transmit-done flag. tx_irq is that flag gated by irq_en. A pulse on irq_ack clears it.
- R10: At most one frame request is outstanding. frm_valid stays low from acceptance until done_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Transmit DMA enable |
| irq_en | input | 1 | Transmit interrupt enable |
| irq_ack | input | 1 | Clears the transmit-done flag |
| desc_base | input | AW | Descriptor ring base address |
| desc_bytes | input | LEN_W | Descriptor ring length in bytes |
| stat_base | input | AW | Completion ring base address |
| stat_bytes | input | LEN_W | Completion ring length in bytes |
| enq_valid | input | 1 | Enqueue strobe |
| enq_cnt | input | ENQ_W | Number of descriptors added |
| desc_cur | output | AW | Current descriptor address |
| stat_cur | output | AW | Current completion record address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address (byte units) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| frm_valid | output | 1 | Frame request valid |
| frm_ready | input | 1 | Datapath accepts the frame request |
| frm_addr | output | AW | Frame buffer address |
| frm_len | output | 12 | Frame length in bytes |
| frm_eof | output | 1 | End-of-frame marker |
| done_valid | input | 1 | Datapath result strobe |
| done_ok | input | 1 | Frame sent without error |
| done_nocarrier | input | 1 | Loss of carrier |
| done_late_coll | input | 1 | Out-of-window collision |
| done_underrun | input | 1 | Transmit underrun |
| done_excess_coll | input | 1 | Excessive collisions |
| done_coll_cnt | input | 5 | Collisions seen for the frame |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
When memory acknowledges at once, an enqueue into an idle engine gives the word-0 read one cycle later and the word-1 read the cycle after that. The frame request follows one cycle later. The record write comes one cycle after done_valid, or straight after the word-1 read for an aborted descriptor. The record, tx_irq and both current addresses all change on the clock edge that completes the write. The bench checks results only at falling edges. It waits for a completion by polling the record's bit 31 in its own memory model within a bounded window, and then checks every port-visible result of that same edge. A quiet window of twenty cycles, with a count of memory reads, proves the absence of accesses.

// File: rtl/tx_ring_engine.sv
`timescale 1ns/1ps
module tx_ring_engine #(
  parameter int AW     = 32,
  parameter int LEN_W  = 16,
  parameter int ENQ_W  = 8,
  parameter int PEND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              irq_en,
  input  logic              irq_ack,
  input  logic [AW-1:0]     desc_base,
  input  logic [LEN_W-1:0]  desc_bytes,
  input  logic [AW-1:0]     stat_base,
  input  logic [LEN_W-1:0]  stat_bytes,
  input  logic              enq_valid,
  input  logic [ENQ_W-1:0]  enq_cnt,
  output logic [AW-1:0]     desc_cur,
  output logic [AW-1:0]     stat_cur,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [AW-1:0]     frm_addr,
  output logic [11:0]       frm_len,
  output logic              frm_eof,
  input  logic              done_valid,
  input  logic              done_ok,
  input  logic              done_nocarrier,
  input  logic              done_late_coll,
  input  logic              done_underrun,
  input  logic              done_excess_coll,
  input  logic [4:0]        done_coll_cnt,
  output logic              tx_irq
);

  localparam int DESC_STEP = 8;
  localparam int STAT_STEP = 4;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_SEND, S_WAIT, S_WRS} st_t;

  st_t               st;
  logic [PEND_W-1:0] pend;
  logic [AW-1:0]     d_cur, s_cur;
  logic [AW-1:0]     buf_addr;
  logic [31:0]       word1;
  logic              r_ok, r_lcrs, r_ow, r_txu, r_xc;
  logic [4:0]        r_nc;
  logic              done_flag;

  logic              rec_done;
  logic              aborted;
  logic [AW-1:0]     d_step, s_step, d_end, s_end, d_next, s_next;
  logic [PEND_W-1:0] pend_add;

  assign aborted  = word1[15];
  assign rec_done = (st == S_WRS) && mem_ack;

  assign d_step = d_cur + AW'(DESC_STEP);
  assign s_step = s_cur + AW'(STAT_STEP);
  assign d_end  = desc_base + AW'(desc_bytes);
  assign s_end  = stat_base + AW'(stat_bytes);
  assign d_next = (d_step >= d_end) ? desc_base : d_step;
  assign s_next = (s_step >= s_end) ? stat_base : s_step;

  assign pend_add = enq_valid ? PEND_W'(enq_cnt) : '0;

  assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_WRS);
  assign mem_we    = (st == S_WRS);
  assign mem_addr  = (st == S_WRS) ? s_cur :
                     (st == S_RD1) ? d_cur + AW'(4) : d_cur;
  assign mem_wdata = {1'b1, r_ok, aborted, r_lcrs, 1'b0, r_ow, r_txu, r_xc,
                      3'b000, r_nc, 1'b0, word1[30:16]};

  assign frm_valid = (st == S_SEND);
  assign frm_addr  = buf_addr;
  assign frm_len   = word1[11:0];
  assign frm_eof   = word1[31];

  assign desc_cur = d_cur;
  assign stat_cur = s_cur;
  assign tx_irq   = done_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (dma_en && pend != '0) st <= S_RD0;
        S_RD0:  if (mem_ack) st <= S_RD1;
        S_RD1:  if (mem_ack) st <= mem_rdata[15] ? S_WRS : S_SEND;
        S_SEND: if (frm_ready) st <= S_WAIT;
        S_WAIT: if (done_valid) st <= S_WRS;
        S_WRS:  if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      pend <= pend + pend_add - (rec_done ? PEND_W'(1) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_cur <= '0;
      s_cur <= '0;
    end else if (st == S_IDLE && !dma_en) begin
      d_cur <= desc_base;
      s_cur <= stat_base;
    end else if (rec_done) begin
      d_cur <= d_next;
      s_cur <= s_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr <= '0;
      word1    <= '0;
    end else if (mem_ack && st == S_RD0) begin
      buf_addr <= mem_rdata[AW-1:0];
    end else if (mem_ack && st == S_RD1) begin
      word1 <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {r_ok, r_lcrs, r_ow, r_txu, r_xc} <= '0;
      r_nc <= '0;
    end else if (st == S_RD1 && mem_ack) begin
      {r_ok, r_lcrs, r_ow, r_txu, r_xc} <= '0;
      r_nc <= '0;
    end else if (st == S_WAIT && done_valid) begin
      r_ok   <= done_ok;
      r_lcrs <= done_nocarrier;
      r_ow   <= done_late_coll;
      r_txu  <= done_underrun;
      r_xc   <= done_excess_coll;
      r_nc   <= done_coll_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (rec_done) done_flag <= 1'b1;
    else if (irq_ack)  done_flag <= 1'b0;
  end

endmodule

// File: rtl/tx_ring_engine_chk.sv
`timescale 1ns/1ps
module tx_ring_engine_chk #(
  parameter int AW     = 32,
  parameter int PEND_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_en,
  input logic              irq_en,
  input logic [2:0]        st,
  input logic [PEND_W-1:0] pend,
  input logic              mem_req,
  input logic              mem_we,
  input logic [31:0]       mem_wdata,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [AW-1:0]     frm_addr,
  input logic [11:0]       frm_len,
  input logic              done_valid,
  input logic              tx_irq
);

  logic in_flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      in_flight <= 1'b0;
    else if (frm_valid && frm_ready) in_flight <= 1'b1;
    else if (done_valid)             in_flight <= 1'b0;
  end

  AST_EMPTY_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && pend == '0) |=> !mem_req); // R8

  AST_DISABLED_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !dma_en) |=> !mem_req); // R8

  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_addr) && $stable(frm_len))); // R2

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !frm_valid); // R10

  AST_RECORD_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[31] && !mem_wdata[27] && !mem_wdata[15])); // R3

  AST_ABORT_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wdata[29]) |-> !mem_wdata[30]); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !tx_irq); // R9

endmodule

bind tx_ring_engine tx_ring_engine_chk #(.AW(AW), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .irq_en(irq_en),
  .st(st), .pend(pend),
  .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_addr(frm_addr), .frm_len(frm_len),
  .done_valid(done_valid), .tx_irq(tx_irq)
);

// File: tb/sim_tx_ring_engine.sv
`timescale 1ns/1ps
module sim_tx_ring_engine;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic        dma_en = 0, irq_en = 0, irq_ack = 0;
  logic [31:0] desc_base = 32'h100, stat_base = 32'h200;
  logic [15:0] desc_bytes = 16'd64, stat_bytes = 16'd32;
  logic        enq_valid = 0;
  logic [7:0]  enq_cnt = 0;
  logic [31:0] desc_cur, stat_cur, mem_addr, mem_wdata, mem_rdata, frm_addr;
  logic        mem_req, mem_we, mem_ack, frm_valid, frm_eof, tx_irq;
  logic        frm_ready = 1;
  logic [11:0] frm_len;
  logic        done_valid = 0;
  logic        r_ok = 1, r_lc = 0, r_ow = 0, r_ur = 0, r_xc = 0;
  logic [4:0]  r_nc = 0;

  tx_ring_engine u0 (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .irq_en(irq_en), .irq_ack(irq_ack),
    .desc_base(desc_base), .desc_bytes(desc_bytes), .stat_base(stat_base), .stat_bytes(stat_bytes),
    .enq_valid(enq_valid), .enq_cnt(enq_cnt), .desc_cur(desc_cur), .stat_cur(stat_cur),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_addr(frm_addr), .frm_len(frm_len), .frm_eof(frm_eof),
    .done_valid(done_valid), .done_ok(r_ok), .done_nocarrier(r_lc), .done_late_coll(r_ow),
    .done_underrun(r_ur), .done_excess_coll(r_xc), .done_coll_cnt(r_nc), .tx_irq(tx_irq));

  logic [31:0] mem [0:255];
  int rd_count = 0, sent = 0, cd = 0;
  logic [31:0] last_addr;
  logic [11:0] last_len;
  logic        last_eof;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_we) rd_count <= rd_count + 1;
  end

  always @(posedge clk) begin
    done_valid <= 1'b0;
    if (cd != 0) begin
      cd <= cd - 1;
      if (cd == 1) done_valid <= 1'b1;
    end
    if (frm_valid && frm_ready) begin
      cd <= 3; sent <= sent + 1;
      last_addr <= frm_addr; last_len <= frm_len; last_eof <= frm_eof;
    end
  end

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int slot, input logic [31:0] a, input logic [14:0] idx,
                          input logic [11:0] len, input bit ab);
    mem[8'h40 + slot*2]     = a;
    mem[8'h40 + slot*2 + 1] = {1'b1, idx, ab, 3'b000, len};
    mem[8'h80 + slot]       = 32'h0;
  endtask

  task automatic enq(input int n);
    @(negedge clk); enq_valid = 1; enq_cnt = 8'(n);
    @(negedge clk); enq_valid = 0;
  endtask

  task automatic wait_rec(input int slot);
    for (int i = 0; i < 200; i++) begin
      if (mem[8'h80 + slot][31]) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!mem_req && !frm_valid && !tx_irq, "R1 idle outputs", {29'b0, mem_req, frm_valid, tx_irq}, 0);
    check(desc_cur == desc_base, "R1 desc_cur reload", desc_cur, desc_base);
    check(stat_cur == stat_base, "R1 stat_cur reload", stat_cur, stat_base);
  endtask

  task automatic t_single_ok;
    int s0 = sent;
    put_desc(0, 32'h1000_0040, 15'd5, 12'd100, 0);
    r_ok = 1; r_nc = 5'd3;
    enq(1);
    wait_rec(0);
    check(mem[8'h80] == 32'hC003_0005, "R3 ok record", mem[8'h80], 32'hC003_0005);
    check(sent == s0 + 1, "R2 one request", sent, s0 + 1);
    check(last_addr == 32'h1000_0040 && last_len == 12'd100 && last_eof,
          "R2 frame fields", last_addr, 32'h1000_0040);
    check(desc_cur == 32'h108, "R7 desc step", desc_cur, 32'h108);
    check(stat_cur == 32'h204, "R7 stat step", stat_cur, 32'h204);
    check(tx_irq, "R9 irq set", tx_irq, 1);
  endtask

  task automatic t_irq;
    irq_en = 0; @(negedge clk);
    check(!tx_irq, "R9 irq masked", tx_irq, 0);
    irq_en = 1; @(negedge clk);
    check(tx_irq, "R9 irq unmasked", tx_irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    check(!tx_irq, "R9 irq cleared", tx_irq, 0);
  endtask

  task automatic t_errors;
    put_desc(1, 32'h1000_0800, 15'd6, 12'd60, 0);
    r_ok = 0; r_lc = 1; r_ow = 1; r_ur = 1; r_xc = 1; r_nc = 5'd16;
    enq(1);
    wait_rec(1);
    check(mem[8'h81] == 32'h9710_0006, "R4 error record", mem[8'h81], 32'h9710_0006);
    r_ok = 1; r_lc = 0; r_ow = 0; r_ur = 0; r_xc = 0; r_nc = 0;
  endtask

  task automatic t_abort;
    int s0 = sent;
    put_desc(2, 32'h1000_1000, 15'd7, 12'd80, 1);
    enq(1);
    wait_rec(2);
    repeat (5) @(negedge clk);
    check(mem[8'h82] == 32'hA000_0007, "R5 abort record", mem[8'h82], 32'hA000_0007);
    check(sent == s0, "R5 abort not sent", sent, s0);
  endtask

  task automatic t_multi_wrap;
    int s0 = sent;
    for (int k = 3; k < 8; k++) put_desc(k, 32'h2000_0000 + k*32'h100, 15'(20 + k), 12'(200 + k), 0);
    enq(5);
    wait_rec(7);
    for (int k = 3; k < 8; k++)
      check(mem[8'h80 + k] == (32'hC000_0000 | (20 + k)), "R6 ordered record",
            mem[8'h80 + k], 32'hC000_0000 | (20 + k));
    check(sent == s0 + 5, "R6 count of sends", sent, s0 + 5);
    check(last_len == 12'd207, "R6 last in order", last_len, 207);
    check(desc_cur == 32'h100, "R7 desc wrap", desc_cur, 32'h100);
    check(stat_cur == 32'h200, "R7 stat wrap", stat_cur, 32'h200);
  endtask

  task automatic t_idle_disable;
    int r0 = rd_count;
    repeat (20) @(negedge clk);
    check(rd_count == r0, "R8 empty quiet", rd_count, r0);
    put_desc(0, 32'h3000_0000, 15'd9, 12'd64, 0);
    enq(1); wait_rec(0);
    check(desc_cur == 32'h108, "R7 after one more", desc_cur, 32'h108);
    dma_en = 0; @(negedge clk); @(negedge clk);
    check(desc_cur == 32'h100 && stat_cur == 32'h200, "R1 reload on disable", desc_cur, 32'h100);
    put_desc(0, 32'h3000_0100, 15'd11, 12'd64, 0);
    r0 = rd_count;
    enq(1);
    repeat (20) @(negedge clk);
    check(rd_count == r0, "R8 disabled quiet", rd_count, r0);
    dma_en = 1;
    wait_rec(0);
    check(mem[8'h80] == 32'hC000_000B, "R6 pending kept", mem[8'h80], 32'hC000_000B);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    dma_en = 1; irq_en = 1;
    t_single_ok();
    t_irq();
    t_errors();
    t_abort();
    t_multi_wrap();
    t_idle_disable();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule